// File: doc/BRIEF.md
# Full-Rate SPI Peripheral with Clock-Domain Crossing

This block is an SPI peripheral in mode 0 (clock idles low, data sampled on the rising SCK edge, MISO updated on the falling edge), moving 8-bit words MSB first. The bit-level shifter, bit counter and transmit pipeline are clocked directly by SCK. The bus may therefore run at any rate up to the system clock. Each complete received word is held in the bus domain, announced by a toggle flag, and brought into the system domain. There it appears as `rx_data` with a single-cycle `rx_valid`. The chip-select line is also synchronized, and its release produces a one-cycle `xfer_done` pulse.

The system side writes the next word to send into a transmit register with a `tx_data`/`tx_valid` pair. The bus domain copies that register at the last rising SCK edge of each word and sends the copy during the following word. Outgoing data is therefore one word behind: the first word of every transaction is 0x00. To answer a command, the controller puts a dummy word between the command and the reply. Neither stream can stall, so there is no ready signal. `rx_valid` must be consumed in the cycle it is high, and `tx_valid` is accepted in every cycle.

Top module: `spi_fast_target`

## Requirements
- R1: With `cs_n` low, the block samples MOSI on each rising SCK edge, MSB first. Every completed 8-bit word appears once on `rx_data`, with `rx_valid` high for it, and it appears exactly once.
- R2: `rx_valid` is never high in two consecutive cycles, and `rx_data` changes only in a cycle where `rx_valid` is high.
- R3: The first word shifted out on MISO in every transaction is 0x00, MSB first, with bits changing on falling SCK edges.
- R4: For N of 1 or more, word N of a transaction carries the value the transmit register held at the last rising SCK edge of word N-1.
- R5: This holds with the default synchronizer depth and SCK at or below the system clock. If a word is loaded within 2 cycles after the `rx_valid` of word N, it is sent as word N+2. This is the command, dummy, reply sequence.
- R6: MISO is driven low whenever `cs_n` is high.
- R7: Raising `cs_n` clears the bit counter, the shifter and the transmit pipeline. A partial word is dropped without any `rx_valid`. The next transaction starts word-aligned and sends 0x00 first.
- R8: Each rising edge of `cs_n` gives exactly one `xfer_done` pulse, one cycle long, within 4 system cycles.
- R9: After `rst`, `rx_valid` and `xfer_done` are low and the transmit register holds 0x00.
- R10: The transmit register keeps its last loaded value. It is sent again in every later word until a new load arrives.
- R11: `tx_valid` is accepted in any cycle without back-pressure. When loads arrive in consecutive cycles, the last one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset, synchronous in the system domain; also clears the word-crossing flag and holding register |
| sck | input | 1 | SPI bus clock from the controller |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller, low while idle |
| tx_data | input | 8 | Next word to transmit |
| tx_valid | input | 1 | Load `tx_data` into the transmit register |
| rx_data | output | 8 | Last received word |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` |
| xfer_done | output | 1 | One-cycle pulse after chip select is released |

## Verification
A stuck or misaligned bit counter shows up at once as wrong words: every following `rx_data` is shifted or missing, and MISO words slip against the reply model within the same transaction. A crossing flag that toggles falsely or misses a toggle shows up at the next word, as an extra or a lost `rx_valid`. A transmit pipeline that is not cleared on chip-select release leaks data into the first word of the next transaction, where 0x00 is expected. The bench compares every clock against a behavioural model at SCK equal to, half of and unrelated to the system clock.

// File: rtl/spi_fast_pkg.sv
package spi_fast_pkg;

  // Width of a counter that indexes n positions.
  function automatic int unsigned cnt_w(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Value a synchronized active-low select idles at.
  localparam bit SEL_IDLE = 1'b1;

endpackage

// File: rtl/sfp_sync.sv
module sfp_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stg;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic src;
    if (i == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = stg[i-1];
    end
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= src;
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sfp_bus_core.sv
module sfp_bus_core
  import spi_fast_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              sck,
  input  logic              cs_n,
  input  logic              rst,
  input  logic              mosi,
  output logic              miso,
  input  logic [DATA_W-1:0] tx_word,
  output logic [DATA_W-1:0] rx_hold,
  output logic              rx_flag
);

  localparam int unsigned    CW   = cnt_w(DATA_W);
  localparam logic [CW-1:0]  LAST = CW'(DATA_W - 1);

  logic [CW-1:0]     bit_cnt;
  logic [DATA_W-2:0] shin;
  logic [DATA_W-1:0] tx_pend;
  logic [DATA_W-1:0] tx_sh;
  logic              word_end;

  assign word_end = (bit_cnt == LAST);

  // Rising-edge side: receive shifter, counter, next-word capture.
  always_ff @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      bit_cnt <= '0;
      shin    <= '0;
      tx_pend <= '0;
    end else begin
      bit_cnt <= word_end ? '0 : bit_cnt + CW'(1);
      shin    <= (DATA_W-1)'({shin, mosi});
      if (word_end) tx_pend <= tx_word;
    end
  end

  // Completed word and its crossing flag survive chip-select release.
  always_ff @(posedge sck or posedge rst) begin
    if (rst) begin
      rx_hold <= '0;
      rx_flag <= 1'b0;
    end else if (word_end) begin
      rx_hold <= {shin, mosi};
      rx_flag <= ~rx_flag;
    end
  end

  // Falling-edge side: transmit shifter, one word behind.
  always_ff @(negedge sck or posedge cs_n) begin
    if (cs_n)                tx_sh <= '0;
    else if (bit_cnt == '0)  tx_sh <= tx_pend;
    else                     tx_sh <= tx_sh << 1;
  end

  assign miso = cs_n ? 1'b0 : tx_sh[DATA_W-1];

endmodule

// File: rtl/sfp_rx_xfer.sv
module sfp_rx_xfer #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flag_async,
  input  logic [DATA_W-1:0] hold_async,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);

  logic flag_s, flag_d, flag_edge;

  sfp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_flag_sync (
    .clk (clk),
    .rst (rst),
    .d   (flag_async),
    .q   (flag_s)
  );

  assign flag_edge = flag_s ^ flag_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_d   <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      flag_d   <= flag_s;
      rx_valid <= flag_edge;
      if (flag_edge) rx_data <= hold_async;
    end
  end

  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  a_r2_data_with_valid: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_data) |-> rx_valid);

endmodule

// File: rtl/sfp_sys_ctrl.sv
module sfp_sys_ctrl
  import spi_fast_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic [DATA_W-1:0] tx_word,
  output logic              xfer_done
);

  logic sel_s, sel_d;

  sfp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SEL_IDLE)) u_sel_sync (
    .clk (clk),
    .rst (rst),
    .d   (cs_n),
    .q   (sel_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_d     <= SEL_IDLE;
      xfer_done <= 1'b0;
      tx_word   <= '0;
    end else begin
      sel_d     <= sel_s;
      xfer_done <= sel_s & ~sel_d;
      if (tx_valid) tx_word <= tx_data;
    end
  end

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done);

  a_r8_done_needs_idle: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> sel_d);

  a_r10_tx_holds: assert property (@(posedge clk) disable iff (rst)
    !tx_valid |=> $stable(tx_word));

endmodule

// File: rtl/spi_fast_target.sv
module spi_fast_target #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              xfer_done
);

  logic [DATA_W-1:0] tx_word;
  logic [DATA_W-1:0] rx_hold;
  logic              rx_flag;

  sfp_bus_core #(.DATA_W(DATA_W)) u_bus (
    .sck     (sck),
    .cs_n    (cs_n),
    .rst     (rst),
    .mosi    (mosi),
    .miso    (miso),
    .tx_word (tx_word),
    .rx_hold (rx_hold),
    .rx_flag (rx_flag)
  );

  sfp_rx_xfer #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .flag_async (rx_flag),
    .hold_async (rx_hold),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid)
  );

  sfp_sys_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_sys (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_word   (tx_word),
    .xfer_done (xfer_done)
  );

  // R6: the pin must be low in any system cycle where select is idle.
  a_r6_idle_low: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !miso);

endmodule

// File: tb/spi_fast_target_test.sv
module spi_fast_target_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sck = 1'b0;
  logic       cs_n = 1'b1;
  logic       mosi = 1'b0;
  logic       miso;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       xfer_done;

  always #5 clk = ~clk;

  spi_fast_target uut (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .tx_data(tx_data), .tx_valid(tx_valid), .rx_data(rx_data),
    .rx_valid(rx_valid), .xfer_done(xfer_done)
  );

  int         checks = 0;
  int         fails = 0;
  logic [7:0] exp_rx[$];
  logic [7:0] seen[$];
  logic [7:0] model_tx = 8'h00;
  bit         responder = 1'b0;
  bit         prev_valid = 1'b0;
  int         done_cnt = 0;
  bit         finished = 1'b0;

  function automatic logic [7:0] reply_of(logic [7:0] x);
    return {x[3:0], x[7:4]} ^ 8'h3C;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model of the transmit register (R9, R10, R11).
  always @(posedge clk) begin
    if (rst) model_tx = 8'h00;
    else if (tx_valid) model_tx = tx_data;
  end

  // Per-clock comparison of the system-side outputs (R1, R2, R6, R8).
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (cs_n) check(miso == 1'b0, "R6 miso idle", miso, 0);
      if (rx_valid) begin
        check(!prev_valid, "R2 valid pulse", prev_valid, 0);
        if (exp_rx.size() == 0) begin
          check(1'b0, "R1 unexpected rx_valid", rx_data, 0);
        end else begin
          logic [7:0] e;
          e = exp_rx.pop_front();
          check(rx_data == e, "R1 rx word", rx_data, e);
        end
      end
      prev_valid = rx_valid;
      if (xfer_done) done_cnt++;
      if (responder) begin
        tx_valid = rx_valid;
        if (rx_valid) tx_data = reply_of(rx_data);
      end
    end
  end

  task automatic spi_txn(input logic [7:0] words[$], input real half);
    logic [7:0] expect_out;
    logic [7:0] got;
    logic [7:0] snap;
    int         done0;
    seen.delete();
    done0 = done_cnt;
    snap = 8'h00;
    @(posedge clk); #2;
    cs_n = 1'b0;
    for (int w = 0; w < words.size(); w++) begin
      expect_out = (w == 0) ? 8'h00 : snap;
      for (int b = 7; b >= 0; b--) begin
        mosi = words[w][b];
        #(half);
        sck = 1'b1;
        got[b] = miso;
        if (b == 0) begin
          snap = model_tx;
          exp_rx.push_back(words[w]);
        end
        #(half);
        sck = 1'b0;
      end
      seen.push_back(got);
      if (w == 0) check(got == expect_out, "R3 first word zero", got, expect_out);
      else        check(got == expect_out, "R4 one word behind", got, expect_out);
    end
    #(half);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(done_cnt == done0 + 1, "R8 one done pulse", done_cnt - done0, 1);
  endtask

  task automatic spi_abort(input int nbits, input real half);
    int done0;
    done0 = done_cnt;
    @(posedge clk); #2;
    cs_n = 1'b0;
    for (int b = 0; b < nbits; b++) begin
      mosi = b[0];
      #(half); sck = 1'b1; #(half); sck = 1'b0;
    end
    #(half);
    cs_n = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk);
    check(done_cnt == done0 + 1, "R8 done after abort", done_cnt - done0, 1);
    check(exp_rx.size() == 0, "R7 no word from partial", exp_rx.size(), 0);
  endtask

  task automatic load_tx(input logic [7:0] v);
    @(negedge clk);
    tx_data = v; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic reply_run(input logic [7:0] cmd, input logic [7:0] dummy, input real half);
    logic [7:0] q[$];
    responder = 1'b1;
    q = '{cmd, dummy, 8'h00, 8'hF0};
    spi_txn(q, half);
    check(seen[2] == reply_of(cmd), "R5 reply after dummy", seen[2], reply_of(cmd));
    responder = 1'b0;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rx_valid == 1'b0, "R9 rx_valid reset", rx_valid, 0);
    check(xfer_done == 1'b0, "R9 xfer_done reset", xfer_done, 0);
    check(miso == 1'b0, "R9 miso reset", miso, 0);

    // R9: no load yet, second word is the reset value of the register.
    begin
      logic [7:0] q[$];
      q = '{8'hA5, 8'h5A};
      spi_txn(q, 5.0);
      check(seen[1] == 8'h00, "R9 tx register zero", seen[1], 0);
    end

    // R5 at three SCK rates: equal, half, unrelated.
    reply_run(8'h81, 8'h00, 5.0);
    reply_run(8'h3E, 8'hFF, 10.0);
    reply_run(8'hC7, 8'h12, 7.3);

    // R10: one load, resent in every later word.
    load_tx(8'h77);
    begin
      logic [7:0] q[$];
      q = '{8'h01, 8'h02, 8'h03};
      spi_txn(q, 5.0);
      check(seen[1] == 8'h77 && seen[2] == 8'h77, "R10 resend", seen[2], 8'h77);
    end

    // R11: back-to-back loads, last one wins.
    @(negedge clk);
    tx_data = 8'h11; tx_valid = 1'b1;
    @(negedge clk);
    tx_data = 8'h22;
    @(negedge clk);
    tx_valid = 1'b0;
    begin
      logic [7:0] q[$];
      q = '{8'h40, 8'h41};
      spi_txn(q, 10.0);
      check(seen[1] == 8'h22, "R11 last load wins", seen[1], 8'h22);
    end

    // R7: partial word dropped, next transaction realigned.
    spi_abort(3, 5.0);
    begin
      logic [7:0] q[$];
      q = '{8'h96, 8'h69};
      spi_txn(q, 7.3);
      check(seen[0] == 8'h00, "R7 first word after abort", seen[0], 0);
    end

    repeat (10) @(posedge clk);
    @(negedge clk);
    check(exp_rx.size() == 0, "R1 every word reported once", exp_rx.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule